// File: doc/BRIEF.md
# Accumulator Processor Core

A small single-cycle processor core that runs one 6-bit instruction on every clock edge. Instructions come from outside the core, one per cycle. The core holds the state: a constant-zero register, seven general registers, an accumulator and an 8-bit program counter. The accumulator is the implied operand of every instruction. Each instruction names at most one register or a 3-bit signed immediate.

The core has one 8-bit output, shared by two values according to the clock level. While the clock is high, the output shows the low six bits of the program counter. While the clock is low, it shows the low six bits of the accumulator. The two top output bits are always zero.

Branches and jumps are relative to the program counter. The offset comes from a register or from the accumulator, it is read as two's complement, and the result wraps modulo 256.

Top module: `tacc_core`

## Requirements
- R1: While rst_ni is low, the program counter, the accumulator and registers x1 to x7 are cleared to 0 at once, without waiting for a clock edge.
- R2: Instruction bits [2:0] carry the opcode and bits [5:3] carry the argument. Opcode 000 loads the argument into the accumulator as a signed value from -4 to 3, sign-extended to 8 bits.
- R3: Opcode 001 sets the accumulator to the accumulator plus the register named by the argument, modulo 256.
- R4: Opcode 011 copies the register named by the argument into the accumulator.
- R5: Opcode 100 copies the accumulator into the register named by the argument and leaves the accumulator unchanged. A write to x0 is discarded, and x0 always reads as 0.
- R6: Opcode 110 replaces the accumulator with its bitwise inverse.
- R7: Opcode 010 adds the named register to the program counter when the accumulator is zero. Otherwise it adds 1.
- R8: Opcode 101 adds the accumulator, read as two's complement, to the program counter, modulo 256.
- R9: Every opcode other than 010 and 101 advances the program counter by 1. Opcode 111 changes no register.
- R10: While clk_i is high, pins_o equals {2'b00, pc[5:0]}. While clk_i is low, pins_o equals {2'b00, acc[5:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Its level also selects what pins_o shows. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 6 | Instruction: argument in [5:3], opcode in [2:0] |
| pins_o | output | 8 | Program counter while the clock is high, accumulator while it is low. Top two bits are zero. |

## Verification
The bench builds the core with its defaults: 8-bit registers, a 3-bit argument and six visible output bits. With these values all eight register indices and all eight immediates are within reach of random draws. Negative offsets move the counter backwards, and runs of several thousand instructions carry the counter past 255. Because only six bits are visible, the bench keeps a full 8-bit model of every register. Loads bring hidden register state out to the accumulator phase of the output.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ARG_W  = 3;
  localparam int unsigned OPC_W  = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_LI  = 3'd0,
    OP_ADD = 3'd1,
    OP_BEZ = 3'd2,
    OP_LR  = 3'd3,
    OP_SR  = 3'd4,
    OP_JA  = 3'd5,
    OP_NOT = 3'd6,
    OP_NOP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ACC_KEEP, ACC_IMM, ACC_ADD, ACC_REG, ACC_INV
  } acc_sel_e;

  typedef enum logic [1:0] {
    PC_INC, PC_BRZ, PC_JMP
  } pc_sel_e;

  typedef struct packed {
    acc_sel_e acc_sel;
    pc_sel_e  pc_sel;
    logic     rf_we;
  } ctrl_t;
endpackage

// File: rtl/tacc_decode.sv
module tacc_decode
  import tacc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '{acc_sel: ACC_KEEP, pc_sel: PC_INC, rf_we: 1'b0};
    unique case (opcode_e'(opc_i))
      OP_LI:   ctrl_o.acc_sel = ACC_IMM;
      OP_ADD:  ctrl_o.acc_sel = ACC_ADD;
      OP_BEZ:  ctrl_o.pc_sel  = PC_BRZ;
      OP_LR:   ctrl_o.acc_sel = ACC_REG;
      OP_SR:   ctrl_o.rf_we   = 1'b1;
      OP_JA:   ctrl_o.pc_sel  = PC_JMP;
      OP_NOT:  ctrl_o.acc_sel = ACC_INV;
      default: ;
    endcase
  end
endmodule

// File: rtl/tacc_regfile.sv
module tacc_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ARG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ARG_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NREG = 1 << ARG_W;

  logic [DATA_W-1:0] regs [NREG];

  assign regs[0] = '0;  // hard zero, writes dropped

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs[g] <= '0;
      else if (we_i && idx_i == ARG_W'(g))            regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[idx_i];
endmodule

// File: rtl/tacc_acc_unit.sv
module tacc_acc_unit
  import tacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_sel_e          sel_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_d;

  always_comb begin
    unique case (sel_i)
      ACC_IMM: acc_d = imm_i;
      ACC_ADD: acc_d = acc_o + rdata_i;
      ACC_REG: acc_d = rdata_i;
      ACC_INV: acc_d = ~acc_o;
      default: acc_d = acc_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else         acc_o <= acc_d;
  end

  AST_LI_LOADS_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == ACC_IMM |=> acc_o == $past(imm_i)); // R2
  AST_NOT_INVERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == ACC_INV |=> acc_o == ~$past(acc_o)); // R6
  AST_KEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == ACC_KEEP |=> $stable(acc_o)); // R5
endmodule

// File: rtl/tacc_pc_unit.sv
module tacc_pc_unit
  import tacc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pc_sel_e           sel_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] pc_o
);
  logic [DATA_W-1:0] step;

  always_comb begin
    unique case (sel_i)
      PC_BRZ:  step = (acc_i == '0) ? rdata_i : DATA_W'(1);
      PC_JMP:  step = acc_i;
      default: step = DATA_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else         pc_o <= pc_o + step;
  end

  AST_PC_SEQUENTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == PC_INC |=> pc_o == $past(pc_o) + DATA_W'(1)); // R9
  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PC_BRZ && acc_i != '0) |=> pc_o == $past(pc_o) + DATA_W'(1)); // R7
endmodule

// File: rtl/tacc_core.sv
module tacc_core
  import tacc_pkg::*;
#(
  parameter int unsigned DATA_W = tacc_pkg::DATA_W,
  parameter int unsigned ARG_W  = tacc_pkg::ARG_W,
  parameter int unsigned SHOW_W = 6,
  parameter int unsigned PIN_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ARG_W+OPC_W-1:0] insn_i,
  output logic [PIN_W-1:0]       pins_o
);
  localparam int unsigned PAD_W = PIN_W - SHOW_W;
  localparam int unsigned EXT_W = DATA_W - ARG_W;

  logic [OPC_W-1:0]  opc;
  logic [ARG_W-1:0]  arg;
  logic [DATA_W-1:0] imm, rdata, acc, pc;
  ctrl_t             ctrl;

  assign opc = insn_i[OPC_W-1:0];
  assign arg = insn_i[ARG_W+OPC_W-1:OPC_W];
  assign imm = {{EXT_W{arg[ARG_W-1]}}, arg};

  tacc_decode u_dec (.opc_i(opc), .ctrl_o(ctrl));

  tacc_regfile #(.DATA_W(DATA_W), .ARG_W(ARG_W)) u_rf (
    .clk_i, .rst_ni, .we_i(ctrl.rf_we), .idx_i(arg), .wdata_i(acc), .rdata_o(rdata)
  );

  tacc_acc_unit #(.DATA_W(DATA_W)) u_acc (
    .clk_i, .rst_ni, .sel_i(ctrl.acc_sel), .imm_i(imm), .rdata_i(rdata), .acc_o(acc)
  );

  tacc_pc_unit #(.DATA_W(DATA_W)) u_pc (
    .clk_i, .rst_ni, .sel_i(ctrl.pc_sel), .acc_i(acc), .rdata_i(rdata), .pc_o(pc)
  );

  // clock level picks the shown value
  assign pins_o = clk_i ? {{PAD_W{1'b0}}, pc[SHOW_W-1:0]}
                        : {{PAD_W{1'b0}}, acc[SHOW_W-1:0]};

  AST_X0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == OP_LR && arg == '0) |=> acc == '0); // R5
  AST_JA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc == OP_JA |=> pc == $past(pc) + $past(acc)); // R8
  AST_NOP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc == OP_NOP |=> $stable(acc)); // R9
endmodule

// File: tb/tacc_core_tb_top.sv
module tacc_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] insn_i = 6'd0;
  logic [7:0] pins_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_pc, m_acc;
  logic [7:0] m_rf [8];

  tacc_core dut_i (.clk_i, .rst_ni, .insn_i, .pins_o);

  always #5 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R7";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R8";
      3'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 8'd0; m_acc = 8'd0;
    for (int i = 0; i < 8; i++) m_rf[i] = 8'd0;
  endtask

  task automatic model_exec(input logic [5:0] ins);
    logic [2:0] op, a;
    logic [7:0] r;
    op = ins[2:0]; a = ins[5:3];
    r = (a == 3'd0) ? 8'd0 : m_rf[a];
    case (op)
      3'd0: begin m_acc = {{5{a[2]}}, a}; m_pc = m_pc + 8'd1; end
      3'd1: begin m_acc = m_acc + r;      m_pc = m_pc + 8'd1; end
      3'd2: m_pc = m_pc + ((m_acc == 8'd0) ? r : 8'd1);
      3'd3: begin m_acc = r;              m_pc = m_pc + 8'd1; end
      3'd4: begin if (a != 3'd0) m_rf[a] = m_acc; m_pc = m_pc + 8'd1; end
      3'd5: m_pc = m_pc + m_acc;
      3'd6: begin m_acc = ~m_acc;         m_pc = m_pc + 8'd1; end
      default: m_pc = m_pc + 8'd1;
    endcase
  endtask

  // entered just after a falling edge
  task automatic step(input logic [5:0] ins);
    string t;
    t = op_tag(ins[2:0]);
    insn_i = ins;
    @(posedge clk_i);
    model_exec(ins);
    #2 check({"R10 pc ", t}, pins_o, {2'b00, m_pc[5:0]});
    @(negedge clk_i);
    #2 check({"R10 acc ", t}, pins_o, {2'b00, m_acc[5:0]});
  endtask

  function automatic logic [5:0] mk(input logic [2:0] a, input logic [2:0] op);
    return {a, op};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk_i); @(negedge clk_i);
    #2 check("R1 reset acc", pins_o, 8'h00);
    @(posedge clk_i); #2 check("R1 reset pc", pins_o, 8'h00);
    @(negedge clk_i); #2;
    rst_ni = 1'b1;

    // directed corners
    step(mk(3'b100, 3'd0));             // R2: li -4 -> 0xFC
    step(mk(3'b011, 3'd0));             // R2: li 3
    step(mk(3'd1, 3'd4));               // R5: x1 = 3
    step(mk(3'd0, 3'd4));               // R5: write x0 dropped
    step(mk(3'd0, 3'd3));               // R5/R4: x0 reads 0
    step(mk(3'd1, 3'd1));               // R3: 0+3
    step(mk(3'd1, 3'd1));               // R3
    step(mk(3'd0, 3'd6));               // R6
    step(mk(3'd0, 3'd7));               // R9 nop
    step(mk(3'd0, 3'd5));               // R8: negative jump
    step(mk(3'b111, 3'd0));             // li -1
    step(mk(3'd2, 3'd4));               // x2 = 0xFF
    step(mk(3'd0, 3'd2));               // R7: not taken, acc != 0
    step(mk(3'd0, 3'd0));               // li 0
    step(mk(3'd2, 3'd2));               // R7: taken, backwards by 1
    step(mk(3'd1, 3'd2));               // R7: taken, +3
    step(mk(3'd0, 3'd2));               // R7: taken via x0 -> stays
    step(mk(3'd2, 3'd3));               // R4: lr x2

    for (int n = 0; n < 3000; n++) step(6'($urandom));

    // asynchronous reset mid-run (R1)
    step(mk(3'b011, 3'd0));
    step(mk(3'd5, 3'd4));
    rst_ni = 1'b0;
    #1 check("R1 async acc", pins_o, 8'h00);
    model_reset();
    @(posedge clk_i); #2 check("R1 async pc", pins_o, 8'h00);
    @(negedge clk_i); #2;
    rst_ni = 1'b1;
    for (int i = 1; i < 8; i++) step(mk(3'(i), 3'd3));  // R1: regs cleared

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule